// File: doc/BRIEF.md
# Byte-Lane Merge and Upper-Half Immediate Logic Unit

This execute-stage unit for a 32-bit RISC core computes three logic operations that plain AND/OR datapaths do not cover. Two of them apply a 16-bit immediate to the upper half of a register only, so the lower half always passes through untouched. The first ANDs the upper half with the immediate. The second ORs the immediate into the upper half. The third builds a word byte by byte: each of the four byte lanes comes from one of two source operands, chosen by a 4-bit lane-select field.

The unit is purely combinational. Operands arrive on a valid/ready stream and leave the same cycle. The output handshake is a direct pass-through: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. When downstream deasserts `out_ready`, the upstream stage must hold its operands stable. Because the unit has no storage, the result stays valid for as long as the inputs are held. `wr_en` tells the register-file writer whether the presented result should be written.

Instruction decode, the register file and operand forwarding sit outside this unit. The two-operand alias form, where the destination is also the first source, needs nothing special here: the result depends only on the operand values.

Top module: `bytemerge_unit`

## Requirements
- R1: With `op` = 2'b00, `result` = `src_a` AND {`imm`, 16'hFFFF}. Bits 15:0 equal `src_a[15:0]`, and bits 31:16 equal `src_a[31:16]` AND `imm`.
- R2: With `op` = 2'b01, `result` = `src_a` OR {`imm`, 16'h0000}. Bits 15:0 equal `src_a[15:0]`.
- R3: With `op` = 2'b10, byte lane i of `result` (lane 0 = bits 7:0, lane 3 = bits 31:24) is taken from `src_b` when `lane_sel[i]` is 1 and from `src_a` when it is 0. Each lane is chosen independently.
- R4: With `op` = 2'b10, `lane_sel` = 4'b0000 returns `src_a` exactly, and `lane_sel` = 4'b1111 returns `src_b` exactly.
- R5: `op` = 2'b11 is reserved. It drives `result` to zero and holds `wr_en` low, even while `in_valid` is high.
- R6: The stream is combinational. `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. `result` is valid in the cycle the operands are applied and does not depend on `out_ready`.
- R7: `wr_en` is high exactly when `in_valid` is high and `op` is one of 00, 01 or 10.
- R8: When both sources carry the same value (the alias case), a merge returns that value for every `lane_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operands and operation are presented |
| in_ready | output | 1 | Unit can accept; mirrors out_ready |
| op | input | 2 | 00 AND-upper, 01 OR-upper, 10 lane merge, 11 reserved |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand (merge only) |
| imm | input | 16 | Immediate for the upper-half operations |
| lane_sel | input | 4 | Per-lane source select for merge, 1 = src_b |
| out_valid | output | 1 | Result is presented; mirrors in_valid |
| out_ready | input | 1 | Downstream accepts the result |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result should be written back |

## Verification
The unit holds no state, so any wrong internal path appears at `result` or `wr_en` in the same cycle the operands are applied, and disappears when they change. A lane mux wired to the wrong source or index shows up as a single corrupted byte under one `lane_sel` pattern. For that reason the bench sweeps all sixteen lane patterns with operands whose bytes are distinct. A lower half altered by an upper-immediate operation shows up at once in `result[15:0]`.

// File: rtl/bytemerge_pkg.sv
package bytemerge_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    OP_AND_UP = 2'b00,
    OP_OR_UP  = 2'b01,
    OP_MERGE  = 2'b10,
    OP_RSVD   = 2'b11
  } bm_op_e;
endpackage

// File: rtl/upper_imm_logic.sv
module upper_imm_logic #(
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] a,
  input  logic [HALF_W-1:0] imm,
  output logic [WORD_W-1:0] and_res,
  output logic [WORD_W-1:0] or_res
);
  logic [WORD_W-1:0] and_mask;
  logic [WORD_W-1:0] or_mask;

  always_comb begin
    and_mask = {imm, {HALF_W{1'b1}}};
    or_mask  = {imm, {HALF_W{1'b0}}};
    and_res  = a & and_mask;
    or_res   = a | or_mask;
  end

  always_comb begin
    // R1: the lower half passes through, and no bit is set that a lacked
    a_r1_low_pass: assert (and_res[HALF_W-1:0] == a[HALF_W-1:0]);
    a_r1_no_new_ones: assert ((and_res & ~a) == '0);
    // R2: the lower half passes through, and no bit of a is cleared
    a_r2_low_pass: assert (or_res[HALF_W-1:0] == a[HALF_W-1:0]);
    a_r2_keeps_ones: assert ((a & ~or_res) == '0);
  end
endmodule

// File: rtl/byte_lane_merge.sv
module byte_lane_merge #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [LANES-1:0]  sel,
  output logic [WORD_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = sel[g] ? b[g*LANE_W +: LANE_W]
                                               : a[g*LANE_W +: LANE_W];
  end

  always_comb begin
    // R4: all-clear and all-set selects return a whole source
    a_r4_all_a: assert (sel != '0 || merged == a);
    a_r4_all_b: assert (sel != '1 || merged == b);
    // R8: equal sources give that value whatever the select
    a_r8_alias: assert (a != b || merged == a);
  end
endmodule

// File: rtl/bytemerge_unit.sv
module bytemerge_unit (
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  op,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [15:0] imm,
  input  logic [3:0]  lane_sel,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] result,
  output logic        wr_en
);
  import bytemerge_pkg::*;

  logic [WORD_W-1:0] and_res;
  logic [WORD_W-1:0] or_res;
  logic [WORD_W-1:0] merge_res;
  logic              op_known;

  upper_imm_logic #(.WORD_W(WORD_W)) u_upper (
    .a(src_a), .imm(imm), .and_res(and_res), .or_res(or_res)
  );

  byte_lane_merge #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_merge (
    .a(src_a), .b(src_b), .sel(lane_sel), .merged(merge_res)
  );

  always_comb begin
    op_known = 1'b1;
    unique case (bm_op_e'(op))
      OP_AND_UP: result = and_res;
      OP_OR_UP:  result = or_res;
      OP_MERGE:  result = merge_res;
      default: begin
        result   = '0;
        op_known = 1'b0;
      end
    endcase
  end

  assign wr_en     = in_valid & op_known;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  always_comb begin
    // R5: the reserved code yields zero and no write
    a_r5_reserved: assert (op != 2'b11 || (result == '0 && !wr_en));
    // R6: the handshake passes straight through
    a_r6_flow: assert (out_valid == in_valid && in_ready == out_ready);
    // R7: a write is only requested alongside a valid result
    a_r7_we_valid: assert (!wr_en || out_valid);
  end
endmodule

// File: tb/bytemerge_unit_test.sv
module bytemerge_unit_test;
  logic        clk = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready, wr_en;
  logic [1:0]  op;
  logic [31:0] src_a, src_b, result;
  logic [15:0] imm;
  logic [3:0]  lane_sel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bytemerge_unit uut (
    .in_valid(in_valid), .in_ready(in_ready), .op(op), .src_a(src_a),
    .src_b(src_b), .imm(imm), .lane_sel(lane_sel), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wr_en(wr_en)
  );

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [3:0] s);
    logic [31:0] r;
    case (o)
      2'b00: r = {a[31:16] & im, a[15:0]};
      2'b01: r = {a[31:16] | im, a[15:0]};
      2'b10: for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i] ? b[i*8 +: 8] : a[i*8 +: 8];
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [3:0] s);
    @(negedge clk);
    in_valid = v; op = o; src_a = a; src_b = b; imm = im; lane_sel = s;
    #2;
  endtask

  task automatic t_reset_state;
    check("R6 idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R7 idle wr_en", {31'b0, wr_en}, 32'h0);
  endtask

  task automatic t_and_upper;
    apply(1, 2'b00, 32'hDEAD_BEEF, 32'h0, 16'h0F0F, 4'h0);
    check("R1 and-upper", result, 32'h0E0D_BEEF);
    check("R7 and-upper wr_en", {31'b0, wr_en}, 32'h1);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a = $urandom; logic [15:0] im = 16'($urandom);
      apply(1, 2'b00, a, $urandom, im, 4'($urandom));
      check("R1 and-upper random", result, model(2'b00, a, 0, im, 0));
    end
  endtask

  task automatic t_or_upper;
    apply(1, 2'b01, 32'h1234_5678, 32'hFFFF_FFFF, 16'hA000, 4'hF);
    check("R2 or-upper", result, 32'hB234_5678);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a = $urandom; logic [15:0] im = 16'($urandom);
      apply(1, 2'b01, a, $urandom, im, 4'($urandom));
      check("R2 or-upper random", result, model(2'b01, a, 0, im, 0));
    end
  endtask

  task automatic t_merge_all_masks;
    for (int m = 0; m < 16; m++) begin
      apply(1, 2'b10, 32'hA3A2_A1A0, 32'hB3B2_B1B0, 16'hFFFF, 4'(m));
      check("R3 merge lane pattern", result, model(2'b10, 32'hA3A2_A1A0, 32'hB3B2_B1B0, 0, 4'(m)));
    end
    apply(1, 2'b10, 32'hA3A2_A1A0, 32'hB3B2_B1B0, 16'h0, 4'b0101);
    check("R3 merge 0101", result, 32'hA3B2_A1B0);
    for (int k = 0; k < 32; k++) begin
      logic [31:0] a = $urandom; logic [31:0] b = $urandom;
      for (int m = 0; m < 16; m++) begin
        apply(1, 2'b10, a, b, 16'($urandom), 4'(m));
        check("R3 merge random", result, model(2'b10, a, b, 0, 4'(m)));
      end
    end
  endtask

  task automatic t_merge_extremes;
    apply(1, 2'b10, 32'h0102_0304, 32'hF0E0_D0C0, 16'h0, 4'b0000);
    check("R4 mask 0000", result, 32'h0102_0304);
    apply(1, 2'b10, 32'h0102_0304, 32'hF0E0_D0C0, 16'h0, 4'b1111);
    check("R4 mask 1111", result, 32'hF0E0_D0C0);
  endtask

  task automatic t_reserved;
    apply(1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 4'hF);
    check("R5 reserved result", result, 32'h0);
    check("R5 reserved wr_en", {31'b0, wr_en}, 32'h0);
  endtask

  task automatic t_handshake;
    out_ready = 1'b0;
    apply(1, 2'b01, 32'h0000_00FF, 0, 16'h8001, 4'h0);
    check("R6 in_ready follows out_ready low", {31'b0, in_ready}, 32'h0);
    check("R6 out_valid same cycle", {31'b0, out_valid}, 32'h1);
    check("R6 result under backpressure", result, 32'h8001_00FF);
    out_ready = 1'b1; #1;
    check("R6 in_ready follows out_ready high", {31'b0, in_ready}, 32'h1);
    check("R6 result unchanged by ready", result, 32'h8001_00FF);
    apply(0, 2'b10, 32'h1, 32'h2, 0, 4'h1);
    check("R7 no write without valid", {31'b0, wr_en}, 32'h0);
    check("R6 out_valid low", {31'b0, out_valid}, 32'h0);
    apply(1, 2'b10, 32'h1, 32'h2, 0, 4'h1);
    check("R7 merge wr_en", {31'b0, wr_en}, 32'h1);
  endtask

  task automatic t_alias;
    for (int m = 0; m < 16; m++) begin
      apply(1, 2'b10, 32'h5A69_C33C, 32'h5A69_C33C, 0, 4'(m));
      check("R8 alias merge", result, 32'h5A69_C33C);
    end
  endtask

  initial begin
    in_valid = 0; out_ready = 1; op = 0; src_a = 0; src_b = 0; imm = 0; lane_sel = 0;
    #5;
    t_reset_state();
    t_and_upper();
    t_or_upper();
    t_merge_all_masks();
    t_merge_extremes();
    t_reserved();
    t_handshake();
    t_alias();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule